// File: doc/BRIEF.md
# Instruction Fetch Stage Controller

This block decides, once per clock, what the instruction fetch stage of a pipelined processor does: fetch, hold, flush or wait. It takes flush and hold requests from the later pipeline stages and the instruction cache's miss and refill signals. A flush from retirement outranks the reorder buffer's drain indication, which outranks a flush from the decoder. Hold requests come next. From this it drives a fetch strobe, a program-counter redirect, branch-predictor repair and training commands, and a cancel to the instruction cache. It also keeps three saturating activity counters.

The surrounding fetch datapath uses `fetchEn` to start a cache access in the current cycle. It takes `redirPc` whenever `redirValid` is high, and it reports the outcome of a fetch on `icMiss` and `fetchFault` in the same cycle as `fetchEn`. When a missed line arrives, `icDone` moves the controller to a refill state. In that state the next fetch uses the returned line (`useMissLine`) rather than a new access. Leaving the hold state costs one idle cycle. Leaving the flush state does not: fetch restarts in that same cycle.

Top module: `fetch_ctl_top`

## Requirements
- R1: After reset the state output is Running and all three counters are zero. The state codes are Running=0, Blocked=1, Squashing=2, MissWait=3, Refill=4.
- R2: A retirement flush (`cmtSquash`) overrides every other input in its cycle. It raises `redirValid` with `redirPc`=`cmtTarget`, raises no `fetchEn`, and moves the state to Squashing.
- R3: Every flush from retirement or decode raises `bpSquash` with that source's sequence number on `bpSeq`. `bpFix` copies the source's mispredict flag; when it is high, `bpFixPc` and `bpFixTaken` carry the source's target and taken bit, and otherwise both are zero. When `cmtSquash` is low and `cmtSeqValid` is high, `bpUpdate` is raised with `bpUpdSeq`=`cmtSeq`. Idle command fields are zero.
- R4: Without a retirement flush, `robSquashing` moves the state to Squashing, and no fetch, redirect or decode-side action occurs in that cycle.
- R5: A decode flush always produces a predictor squash. It redirects to `decTarget` and raises `flushYounger` only when the state is not Squashing. A decode flush in Squashing falls through to the checks below.
- R6: If any bit of `stallVec` is high (bit 0 decode, 1 rename, 2 execute, 3 commit) and no higher-priority action applies, the state becomes Blocked and `fetchEn` stays low.
- R7: In Blocked with no stall and no held fault, the state returns to Running and `fetchEn` stays low for that cycle.
- R8: In Squashing with nothing pending, `fetchEn` is raised in the same cycle and the state becomes Running.
- R9: A fetch in Running or Squashing that reports `icMiss` moves the state to MissWait. MissWait never fetches, and `icDone` moves it to Refill. In Refill the next fetch raises `useMissLine` and returns to Running.
- R10: `icCancel` rises exactly when a retirement flush or a decode redirect occurs in MissWait.
- R11: A fetch reporting `fetchFault` moves the state to Blocked. The fault is held, and fetch stays off even with no stall, until a retirement flush or decode redirect clears it.
- R12: `squashCycles` counts cycles with a retirement flush, ROB drain or decode redirect. `blockedCycles` counts cycles with a stall, a Blocked exit, or a held-fault block. `fetchCycles` counts `fetchEn` cycles. Each counter saturates at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cmtSquash | input | 1 | Flush request from retirement |
| cmtMispredict | input | 1 | Retirement flush is a branch mispredict |
| cmtTaken | input | 1 | Resolved direction for retirement mispredict |
| cmtTarget | input | AW | Restart address from retirement |
| cmtSeq | input | SW | Sequence number from retirement |
| cmtSeqValid | input | 1 | Retirement reports a completed sequence number |
| robSquashing | input | 1 | Reorder buffer still draining a flush |
| decSquash | input | 1 | Flush request from decode |
| decMispredict | input | 1 | Decode flush is a branch mispredict |
| decTaken | input | 1 | Resolved direction for decode mispredict |
| decTarget | input | AW | Restart address from decode |
| decSeq | input | SW | Sequence number from decode |
| stallVec | input | 4 | Hold requests: decode, rename, execute, commit |
| icMiss | input | 1 | Current fetch missed in the cache |
| icDone | input | 1 | Outstanding miss has returned |
| fetchFault | input | 1 | Current fetch faulted |
| fetchEn | output | 1 | Fetch this cycle |
| useMissLine | output | 1 | Fetch uses the returned miss line |
| icCancel | output | 1 | Cancel the outstanding cache miss |
| redirValid | output | 1 | Program counter redirect |
| redirPc | output | AW | Redirect address |
| flushYounger | output | 1 | Drop instructions younger than the decode flush |
| bpSquash | output | 1 | Predictor squash command |
| bpSeq | output | SW | Sequence number for predictor squash |
| bpFix | output | 1 | Squash carries a correction |
| bpFixPc | output | AW | Corrected next address |
| bpFixTaken | output | 1 | Corrected direction |
| bpUpdate | output | 1 | Predictor training command |
| bpUpdSeq | output | SW | Sequence number to train |
| stateOut | output | 3 | Current state code |
| squashCycles | output | CW | Flush cycle counter |
| blockedCycles | output | CW | Hold cycle counter |
| fetchCycles | output | CW | Fetch cycle counter |

## Verification
A wrong state register is not held back for long. In the next cycle it shows up at the ports as a missing or extra `fetchEn`, a suppressed or spurious decode redirect, or a `icCancel` in the wrong place, and `stateOut` exposes it directly. A wrong priority decision shows up combinationally in the same cycle on the redirect and predictor outputs. A wrong counter increment becomes visible one cycle later. Because the bench compares every output on every cycle, each of these faults is reported within a cycle of its cause.

// File: rtl/fetch_ctl_pkg.sv
package fetch_ctl_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_BLOCK  = 3'd1,
    ST_SQUASH = 3'd2,
    ST_MISS   = 3'd3,
    ST_REFILL = 3'd4
  } fetchState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic takeCmt;     // redirect/squash sourced from retirement
    logic takeDec;     // redirect sourced from decode
    logic bpFromCmt;   // predictor squash from retirement
    logic bpFromDec;   // predictor squash from decode
    logic incSquash;
    logic incBlocked;
    logic incFetch;
  } ctlStrobe_t;

  localparam int NUM_CNT = 3;

endpackage

// File: rtl/fetch_ctl_satcnt.sv
module fetch_ctl_satcnt #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rstN)                   cnt <= '0;
    else if (inc && cnt != TOP)  cnt <= cnt + 1'b1;
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == TOP) |=> (cnt == TOP)); // R12
  AST_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (cnt >= $past(cnt))); // R12
endmodule

// File: rtl/fetch_ctl_fsm.sv
module fetch_ctl_fsm
  import fetch_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmtSquash,
  input  logic        cmtSeqValid,
  input  logic        robSquashing,
  input  logic        decSquash,
  input  logic [3:0]  stallVec,
  input  logic        icMiss,
  input  logic        icDone,
  input  logic        fetchFault,
  output fetchState_e state,
  output ctlStrobe_t  strobe,
  output logic        fetchEn,
  output logic        useMissLine,
  output logic        icCancel,
  output logic        bpUpdate,
  output logic        flushYounger
);
  fetchState_e nxtState;
  logic        faultHeld, faultNxt;
  logic        doFetch, decRedir, anyStall;

  assign anyStall = |stallVec;

  always_comb begin
    nxtState     = state;
    faultNxt     = faultHeld;
    strobe       = '0;
    icCancel     = 1'b0;
    bpUpdate     = 1'b0;
    flushYounger = 1'b0;
    doFetch      = 1'b0;
    decRedir     = 1'b0;
    if (cmtSquash) begin
      strobe.takeCmt   = 1'b1;
      strobe.bpFromCmt = 1'b1;
      strobe.incSquash = 1'b1;
      icCancel         = (state == ST_MISS);
      faultNxt         = 1'b0;
      nxtState         = ST_SQUASH;
    end else begin
      bpUpdate = cmtSeqValid;
      if (robSquashing) begin
        strobe.incSquash = 1'b1;
        nxtState         = ST_SQUASH;
      end else begin
        strobe.bpFromDec = decSquash;
        decRedir         = decSquash && (state != ST_SQUASH);
        if (decRedir) begin
          strobe.takeDec   = 1'b1;
          strobe.incSquash = 1'b1;
          flushYounger     = 1'b1;
          icCancel         = (state == ST_MISS);
          faultNxt         = 1'b0;
          nxtState         = ST_SQUASH;
        end else if (anyStall) begin
          strobe.incBlocked = 1'b1;
          nxtState          = ST_BLOCK;
        end else if (state == ST_BLOCK) begin
          strobe.incBlocked = 1'b1;
          if (!faultHeld) nxtState = ST_RUN;
        end else if (state == ST_MISS) begin
          if (icDone) nxtState = ST_REFILL;
        end else if (faultHeld) begin
          strobe.incBlocked = 1'b1;
          nxtState          = ST_BLOCK;
        end else begin
          doFetch = 1'b1;
        end
      end
    end
    fetchEn     = doFetch;
    useMissLine = doFetch && (state == ST_REFILL);
    if (doFetch) begin
      strobe.incFetch = 1'b1;
      if (fetchFault) begin
        faultNxt = 1'b1;
        nxtState = ST_BLOCK;
      end else if (icMiss && state != ST_REFILL) begin
        nxtState = ST_MISS;
      end else begin
        nxtState = ST_RUN;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_RUN;
      faultHeld <= 1'b0;
    end else begin
      state     <= nxtState;
      faultHeld <= faultNxt;
    end
  end

  AST_CMT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    cmtSquash |=> (state == ST_SQUASH)); // R2
  AST_ROB_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (robSquashing && !cmtSquash) |=> (state == ST_SQUASH)); // R4
  AST_STALL_NO_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    anyStall |-> !fetchEn); // R6
  AST_UNBLOCK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BLOCK) |-> !fetchEn); // R7
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MISS) |-> !fetchEn); // R9
  AST_CANCEL_IN_MISS: assert property (@(posedge clk) disable iff (!rstN)
    icCancel |-> (state == ST_MISS)); // R10
  AST_ONE_REDIRECT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.takeCmt, strobe.takeDec})); // R5
endmodule

// File: rtl/fetch_ctl_dp.sv
module fetch_ctl_dp
  import fetch_ctl_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 16,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    strobe,
  input  logic          bpUpdate,
  input  logic          cmtMispredict,
  input  logic          cmtTaken,
  input  logic [AW-1:0] cmtTarget,
  input  logic [SW-1:0] cmtSeq,
  input  logic          decMispredict,
  input  logic          decTaken,
  input  logic [AW-1:0] decTarget,
  input  logic [SW-1:0] decSeq,
  output logic          redirValid,
  output logic [AW-1:0] redirPc,
  output logic          bpSquash,
  output logic [SW-1:0] bpSeq,
  output logic          bpFix,
  output logic [AW-1:0] bpFixPc,
  output logic          bpFixTaken,
  output logic [SW-1:0] bpUpdSeq,
  output logic [CW-1:0] squashCycles,
  output logic [CW-1:0] blockedCycles,
  output logic [CW-1:0] fetchCycles
);
  logic [NUM_CNT-1:0] incVec;
  logic [CW-1:0]      cntArr [NUM_CNT];

  always_comb begin
    redirValid = strobe.takeCmt | strobe.takeDec;
    redirPc    = strobe.takeCmt ? cmtTarget : (strobe.takeDec ? decTarget : '0);
    bpSquash   = strobe.bpFromCmt | strobe.bpFromDec;
    bpSeq      = strobe.bpFromCmt ? cmtSeq : (strobe.bpFromDec ? decSeq : '0);
    bpFix      = (strobe.bpFromCmt & cmtMispredict) | (strobe.bpFromDec & decMispredict);
    bpFixPc    = '0;
    bpFixTaken = 1'b0;
    if (strobe.bpFromCmt && cmtMispredict) begin
      bpFixPc    = cmtTarget;
      bpFixTaken = cmtTaken;
    end else if (strobe.bpFromDec && decMispredict) begin
      bpFixPc    = decTarget;
      bpFixTaken = decTaken;
    end
    bpUpdSeq = bpUpdate ? cmtSeq : '0;
  end

  assign incVec = {strobe.incFetch, strobe.incBlocked, strobe.incSquash};

  for (genvar g = 0; g < NUM_CNT; g++) begin : gCnt
    fetch_ctl_satcnt #(.CW(CW)) u_cnt (
      .clk  (clk),
      .rstN (rstN),
      .inc  (incVec[g]),
      .cnt  (cntArr[g])
    );
  end

  assign squashCycles  = cntArr[0];
  assign blockedCycles = cntArr[1];
  assign fetchCycles   = cntArr[2];

  AST_FIX_NEEDS_SQUASH: assert property (@(posedge clk) disable iff (!rstN)
    bpFix |-> bpSquash); // R3
endmodule

// File: rtl/fetch_ctl_top.sv
module fetch_ctl_top
  import fetch_ctl_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 16,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmtSquash,
  input  logic          cmtMispredict,
  input  logic          cmtTaken,
  input  logic [AW-1:0] cmtTarget,
  input  logic [SW-1:0] cmtSeq,
  input  logic          cmtSeqValid,
  input  logic          robSquashing,
  input  logic          decSquash,
  input  logic          decMispredict,
  input  logic          decTaken,
  input  logic [AW-1:0] decTarget,
  input  logic [SW-1:0] decSeq,
  input  logic [3:0]    stallVec,
  input  logic          icMiss,
  input  logic          icDone,
  input  logic          fetchFault,
  output logic          fetchEn,
  output logic          useMissLine,
  output logic          icCancel,
  output logic          redirValid,
  output logic [AW-1:0] redirPc,
  output logic          flushYounger,
  output logic          bpSquash,
  output logic [SW-1:0] bpSeq,
  output logic          bpFix,
  output logic [AW-1:0] bpFixPc,
  output logic          bpFixTaken,
  output logic          bpUpdate,
  output logic [SW-1:0] bpUpdSeq,
  output logic [2:0]    stateOut,
  output logic [CW-1:0] squashCycles,
  output logic [CW-1:0] blockedCycles,
  output logic [CW-1:0] fetchCycles
);
  fetchState_e curState;
  ctlStrobe_t  strobe;

  fetch_ctl_fsm u_fsm (
    .clk          (clk),
    .rstN         (rstN),
    .cmtSquash    (cmtSquash),
    .cmtSeqValid  (cmtSeqValid),
    .robSquashing (robSquashing),
    .decSquash    (decSquash),
    .stallVec     (stallVec),
    .icMiss       (icMiss),
    .icDone       (icDone),
    .fetchFault   (fetchFault),
    .state        (curState),
    .strobe       (strobe),
    .fetchEn      (fetchEn),
    .useMissLine  (useMissLine),
    .icCancel     (icCancel),
    .bpUpdate     (bpUpdate),
    .flushYounger (flushYounger)
  );

  fetch_ctl_dp #(.AW(AW), .SW(SW), .CW(CW)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .bpUpdate      (bpUpdate),
    .cmtMispredict (cmtMispredict),
    .cmtTaken      (cmtTaken),
    .cmtTarget     (cmtTarget),
    .cmtSeq        (cmtSeq),
    .decMispredict (decMispredict),
    .decTaken      (decTaken),
    .decTarget     (decTarget),
    .decSeq        (decSeq),
    .redirValid    (redirValid),
    .redirPc       (redirPc),
    .bpSquash      (bpSquash),
    .bpSeq         (bpSeq),
    .bpFix         (bpFix),
    .bpFixPc       (bpFixPc),
    .bpFixTaken    (bpFixTaken),
    .bpUpdSeq      (bpUpdSeq),
    .squashCycles  (squashCycles),
    .blockedCycles (blockedCycles),
    .fetchCycles   (fetchCycles)
  );

  assign stateOut = curState;
endmodule

// File: tb/fetch_ctl_top_tb.sv
module fetch_ctl_top_tb;
  localparam int AW = 32;
  localparam int SW = 16;
  localparam int CW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic cmtSquash, cmtMispredict, cmtTaken, cmtSeqValid, robSquashing;
  logic decSquash, decMispredict, decTaken, icMiss, icDone, fetchFault;
  logic [AW-1:0] cmtTarget, decTarget;
  logic [SW-1:0] cmtSeq, decSeq;
  logic [3:0] stallVec;

  logic fetchEn, useMissLine, icCancel, redirValid, flushYounger;
  logic bpSquash, bpFix, bpFixTaken, bpUpdate;
  logic [AW-1:0] redirPc, bpFixPc;
  logic [SW-1:0] bpSeq, bpUpdSeq;
  logic [2:0] stateOut;
  logic [CW-1:0] squashCycles, blockedCycles, fetchCycles;

  // small-counter copy for saturation
  logic sFetchEn, sUse, sCancel, sRedir, sFlush, sBpSq, sBpFix, sBpFixT, sBpUpd;
  logic [AW-1:0] sRedirPc, sFixPc;
  logic [SW-1:0] sBpSeq, sUpdSeq;
  logic [2:0] sState;
  logic [3:0] sSq, sBl, sFe;

  fetch_ctl_top #(.AW(AW), .SW(SW), .CW(CW)) u_dut (
    .clk(clk), .rstN(rstN), .cmtSquash(cmtSquash), .cmtMispredict(cmtMispredict),
    .cmtTaken(cmtTaken), .cmtTarget(cmtTarget), .cmtSeq(cmtSeq), .cmtSeqValid(cmtSeqValid),
    .robSquashing(robSquashing), .decSquash(decSquash), .decMispredict(decMispredict),
    .decTaken(decTaken), .decTarget(decTarget), .decSeq(decSeq), .stallVec(stallVec),
    .icMiss(icMiss), .icDone(icDone), .fetchFault(fetchFault), .fetchEn(fetchEn),
    .useMissLine(useMissLine), .icCancel(icCancel), .redirValid(redirValid),
    .redirPc(redirPc), .flushYounger(flushYounger), .bpSquash(bpSquash), .bpSeq(bpSeq),
    .bpFix(bpFix), .bpFixPc(bpFixPc), .bpFixTaken(bpFixTaken), .bpUpdate(bpUpdate),
    .bpUpdSeq(bpUpdSeq), .stateOut(stateOut), .squashCycles(squashCycles),
    .blockedCycles(blockedCycles), .fetchCycles(fetchCycles)
  );

  fetch_ctl_top #(.AW(AW), .SW(SW), .CW(4)) u_sat (
    .clk(clk), .rstN(rstN), .cmtSquash(cmtSquash), .cmtMispredict(cmtMispredict),
    .cmtTaken(cmtTaken), .cmtTarget(cmtTarget), .cmtSeq(cmtSeq), .cmtSeqValid(cmtSeqValid),
    .robSquashing(robSquashing), .decSquash(decSquash), .decMispredict(decMispredict),
    .decTaken(decTaken), .decTarget(decTarget), .decSeq(decSeq), .stallVec(stallVec),
    .icMiss(icMiss), .icDone(icDone), .fetchFault(fetchFault), .fetchEn(sFetchEn),
    .useMissLine(sUse), .icCancel(sCancel), .redirValid(sRedir),
    .redirPc(sRedirPc), .flushYounger(sFlush), .bpSquash(sBpSq), .bpSeq(sBpSeq),
    .bpFix(sBpFix), .bpFixPc(sFixPc), .bpFixTaken(sBpFixT), .bpUpdate(sBpUpd),
    .bpUpdSeq(sUpdSeq), .stateOut(sState), .squashCycles(sSq),
    .blockedCycles(sBl), .fetchCycles(sFe)
  );

  int checks = 0;
  int errors = 0;

  // reference model state: 0 run,1 blocked,2 squashing,3 miss wait,4 refill
  int mState = 0;
  bit mFault = 0;
  longint mSq = 0, mBl = 0, mFe = 0;

  task automatic chk(input string tag, input string what, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  function automatic longint satv(input longint v, input longint top);
    return (v > top) ? top : v;
  endfunction

  task automatic clearIn();
    cmtSquash = 0; cmtMispredict = 0; cmtTaken = 0; cmtSeqValid = 0; robSquashing = 0;
    decSquash = 0; decMispredict = 0; decTaken = 0; icMiss = 0; icDone = 0; fetchFault = 0;
    cmtTarget = '0; decTarget = '0; cmtSeq = '0; decSeq = '0; stallVec = '0;
  endtask

  // one cycle: inputs already driven after a falling edge
  task automatic step();
    int nState; bit nFault; bit eFetch, eUse, eCancel, eRedir, eFlush, eSq, eFix, eFixT, eUpd;
    longint ePc, eSeq, eFixPc, eUpdSeq; bit iS, iB, iF;
    #5;
    nState = mState; nFault = mFault;
    eFetch = 0; eUse = 0; eCancel = 0; eRedir = 0; eFlush = 0; eSq = 0; eFix = 0; eFixT = 0;
    eUpd = 0; ePc = 0; eSeq = 0; eFixPc = 0; eUpdSeq = 0; iS = 0; iB = 0; iF = 0;
    if (cmtSquash) begin
      eRedir = 1; ePc = cmtTarget; eSq = 1; eSeq = cmtSeq;
      if (cmtMispredict) begin eFix = 1; eFixPc = cmtTarget; eFixT = cmtTaken; end
      eCancel = (mState == 3); nFault = 0; iS = 1; nState = 2;
    end else begin
      if (cmtSeqValid) begin eUpd = 1; eUpdSeq = cmtSeq; end
      if (robSquashing) begin
        iS = 1; nState = 2;
      end else begin
        if (decSquash) begin
          eSq = 1; eSeq = decSeq;
          if (decMispredict) begin eFix = 1; eFixPc = decTarget; eFixT = decTaken; end
        end
        if (decSquash && mState != 2) begin
          eRedir = 1; ePc = decTarget; eFlush = 1; eCancel = (mState == 3);
          nFault = 0; iS = 1; nState = 2;
        end else if (stallVec != 0) begin
          iB = 1; nState = 1;
        end else if (mState == 1) begin
          iB = 1; if (!mFault) nState = 0;
        end else if (mState == 3) begin
          if (icDone) nState = 4;
        end else if (mFault) begin
          iB = 1; nState = 1;
        end else begin
          eFetch = 1; iF = 1; eUse = (mState == 4);
          if (fetchFault) begin nFault = 1; nState = 1; end
          else if (icMiss && mState != 4) nState = 3;
          else nState = 0;
        end
      end
    end
    chk("R1", "state", stateOut, mState);
    chk(eUse ? "R9" : (mState == 2 ? "R8" : "R7"), "fetchEn", fetchEn, eFetch);
    chk("R9", "useMissLine", useMissLine, eUse);
    chk("R10", "icCancel", icCancel, eCancel);
    chk(cmtSquash ? "R2" : "R5", "redirValid", redirValid, eRedir);
    chk(cmtSquash ? "R2" : "R5", "redirPc", redirPc, ePc);
    chk("R5", "flushYounger", flushYounger, eFlush);
    chk("R3", "bpSquash", bpSquash, eSq);
    chk("R3", "bpSeq", bpSeq, eSeq);
    chk("R3", "bpFix", bpFix, eFix);
    chk("R3", "bpFixPc", bpFixPc, eFixPc);
    chk("R3", "bpFixTaken", bpFixTaken, eFixT);
    chk("R3", "bpUpdate", bpUpdate, eUpd);
    chk("R3", "bpUpdSeq", bpUpdSeq, eUpdSeq);
    chk("R12", "squashCycles", squashCycles, mSq);
    chk("R12", "blockedCycles", blockedCycles, mBl);
    chk("R12", "fetchCycles", fetchCycles, mFe);
    chk("R12", "satSquash", sSq, satv(mSq, 15));
    chk("R12", "satBlocked", sBl, satv(mBl, 15));
    chk("R12", "satFetch", sFe, satv(mFe, 15));
    @(posedge clk);
    mState = nState; mFault = nFault;
    mSq += iS; mBl += iB; mFe += iF;
    @(negedge clk);
    clearIn();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: got hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clearIn();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    // R1 reset state then plain fetching (R8 path via run)
    idle(4);
    // R3 training command
    cmtSeqValid = 1; cmtSeq = 16'h0005; step();
    // R2 retirement flush with mispredict, then restart same cycle (R8)
    cmtSquash = 1; cmtMispredict = 1; cmtTaken = 1; cmtTarget = 32'h0000_1000; cmtSeq = 16'h0007;
    cmtSeqValid = 1; stallVec = 4'hF; decSquash = 1; step();
    idle(2);
    cmtSquash = 1; cmtTarget = 32'h0000_2000; cmtSeq = 16'h0009; step();
    // R4 ROB still draining
    robSquashing = 1; decSquash = 1; decTarget = 32'hBAD0; step();
    robSquashing = 1; cmtSeqValid = 1; cmtSeq = 16'h0011; step();
    idle(1);
    // R5 decode flush while running, then while squashing
    decSquash = 1; decMispredict = 1; decTaken = 1; decTarget = 32'h0000_3000; decSeq = 16'h0020; step();
    decSquash = 1; decTarget = 32'h0000_4000; decSeq = 16'h0021; step();
    idle(1);
    // R6/R7 each stall bit, release costs one idle cycle
    for (int b = 0; b < 4; b++) begin
      stallVec = 4'(1 << b); step();
      stallVec = 4'(1 << b); step();
      idle(2);
    end
    // stall during squashing
    cmtSquash = 1; cmtTarget = 32'h5000; step();
    stallVec = 4'h2; step();
    idle(2);
    // R9 miss, wait, refill
    icMiss = 1; step();
    icMiss = 1; idle(1);
    icMiss = 1; step();
    icDone = 1; step();
    icMiss = 1; step();
    idle(1);
    // R10 cancel by retirement flush and by decode flush
    icMiss = 1; step();
    cmtSquash = 1; cmtTarget = 32'h6000; step();
    idle(1);
    icMiss = 1; step();
    decSquash = 1; decTarget = 32'h7000; decSeq = 16'h0030; step();
    idle(1);
    // R11 fault holds until redirect
    fetchFault = 1; step();
    idle(3);
    robSquashing = 1; step();
    idle(2);
    decSquash = 1; decTarget = 32'h8000; decSeq = 16'h0040; step();
    idle(2);
    fetchFault = 1; step();
    stallVec = 4'h8; step();
    cmtSquash = 1; cmtTarget = 32'h9000; step();
    idle(2);
    // mixed traffic
    for (int n = 0; n < 3000; n++) begin
      cmtSquash     = ($urandom % 23) == 0;
      cmtMispredict = $urandom % 2;
      cmtTaken      = $urandom % 2;
      cmtTarget     = $urandom;
      cmtSeq        = SW'($urandom);
      cmtSeqValid   = ($urandom % 4) == 0;
      robSquashing  = ($urandom % 19) == 0;
      decSquash     = ($urandom % 13) == 0;
      decMispredict = $urandom % 2;
      decTaken      = $urandom % 2;
      decTarget     = $urandom;
      decSeq        = SW'($urandom);
      stallVec      = (($urandom % 6) == 0) ? 4'($urandom) : 4'h0;
      icMiss        = ($urandom % 7) == 0;
      icDone        = ($urandom % 3) == 0;
      fetchFault    = ($urandom % 41) == 0;
      step();
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule